// File: doc/BRIEF.md
# Local register set cache controller

This block manages a small on-chip pool of local register sets that back procedure call and return. Every call hands the callee a fresh set of sixteen 32-bit registers, and every return brings back the caller's set. The sets sit in a circular buffer with a current index and a count of resident frames. Memory is used only when it has to be. A call with all sets occupied first writes the oldest resident set out to its frame in a memory stack. A return whose caller set has already been written out reads that set back before completing.

Each frame owns a fixed 64-byte slot in memory. The frame pointer starts at zero, rises by 64 on each call and drops by 64 on each return. A call or return is requested with a one-cycle strobe while the block is idle, and the block answers with a one-cycle done strobe. Memory traffic uses a word-wide port with a request/ready handshake, so slow memory simply stretches each beat. A small read/write port gives access to the registers of the current set.

Top module: `regset_cache`

## Requirements
- R1: After reset the frame pointer is 0, the call depth is 0, and done, err and mem_req are all low.
- R2: A call accepted while fewer than 4 sets are resident raises done exactly 9 cycles after the accepting clock edge and makes no memory access.
- R3: A return accepted while the caller's set is resident (more than one frame resident) raises done exactly 7 cycles after the accepting edge and makes no memory access.
- R4: A call accepted with all 4 sets resident writes the oldest set's 16 words, register 0 first, to consecutive word addresses starting at fp - 192 (mem_we = 1). With memory always ready, done follows 16 + 9 = 25 cycles after acceptance.
- R5: A return accepted with only one frame resident reads 16 words from consecutive word addresses starting at fp - 64 into the caller's set (mem_we = 0). With memory always ready, done follows 16 + 7 = 23 cycles after acceptance.
- R6: A memory beat completes only on a cycle with mem_req and mem_rdy both high. While mem_rdy is low, mem_addr and mem_wdata hold, and every spill or fill transfers exactly 16 beats.
- R7: The frame pointer rises by 64 when a call completes and falls by 64 when a return completes.
- R8: The register port writes (rf_we) and reads (rf_rdata, combinational on rf_idx) the current set. After nesting deeper than 4 levels and unwinding, every set holds the values written into it before the nested calls.
- R9: A return requested at call depth 0 raises err for one cycle, 1 cycle after acceptance. It raises no done, accesses no memory and leaves the frame pointer and register contents unchanged.
- R10: done is a single-cycle pulse. While the block is busy, further requests and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Call strobe, sampled while idle (priority over return) |
| ret_req | input | 1 | Return strobe, sampled while idle |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle strobe: return with no open call |
| fp | output | 32 | Frame pointer of the current frame |
| rf_we | input | 1 | Write enable for the current set |
| rf_idx | input | 4 | Register number within the current set |
| rf_wdata | input | 32 | Register write data |
| rf_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Spill write data |
| mem_rdata | input | 32 | Fill read data, taken when mem_rdy is high |
| mem_rdy | input | 1 | Memory accepts or returns the beat this cycle |

## Verification
Calls are nested nine deep and unwound with memory always ready. This separates the hit cases (9 and 7 cycles, no beats) from the spill and fill cases (25 and 23 cycles, 16 beats) by exact latency and beat count. Every register of every frame is then compared against a value tagged with its depth and index. A second sweep uses a pseudo-random ready pattern and distinct data, which shows that stalled beats neither skip nor repeat words. A return at depth zero shows that err is raised and that nothing changes.

// File: rtl/regset_cache.sv
module regset_cache #(
  parameter int NSETS    = 4,
  parameter int NREGS    = 16,
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int DEPTH_W  = 16,
  parameter int CALL_LAT = 9,
  parameter int RET_LAT  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_req,
  input  logic          ret_req,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] fp,
  input  logic          rf_we,
  input  logic [$clog2(NREGS)-1:0] rf_idx,
  input  logic [DW-1:0] rf_wdata,
  output logic [DW-1:0] rf_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy
);
  localparam int SW    = $clog2(NSETS);
  localparam int RW    = $clog2(NREGS);
  localparam int CW    = $clog2(NSETS + 1);
  localparam int WB    = DW / 8;
  localparam int FRAME = NREGS * WB;

  typedef enum logic [1:0] {IDLE, SPILL, FILL, WAIT} st_t;
  st_t st;

  logic [DW-1:0]      rf [NSETS*NREGS];
  logic [SW-1:0]      cur;
  logic [CW-1:0]      cnt;
  logic [DEPTH_W-1:0] depth;
  logic [RW-1:0]      beat;
  logic [7:0]         tmr;
  logic               op_call;

  wire [SW-1:0] prev   = cur - 1'b1;
  wire [SW-1:0] oldest = cur + 1'b1;
  wire [AW-1:0] base   = (st == SPILL) ? fp - AW'((NSETS-1)*FRAME) : fp - AW'(FRAME);
  wire          last   = (beat == RW'(NREGS-1));

  assign mem_req   = (st == SPILL) || (st == FILL);
  assign mem_we    = (st == SPILL);
  assign mem_addr  = base + (AW'(beat) << $clog2(WB));
  assign mem_wdata = rf[{oldest, beat}];
  assign rf_rdata  = rf[{cur, rf_idx}];

  always_ff @(posedge clk) begin
    if (st == IDLE && rf_we) rf[{cur, rf_idx}] <= rf_wdata;
    else if (st == FILL && mem_rdy) rf[{prev, beat}] <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cur <= '0; cnt <= CW'(1); depth <= '0; fp <= '0;
      beat <= '0; tmr <= '0; op_call <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        IDLE: begin
          beat <= '0;
          if (call_req) begin
            op_call <= 1'b1;
            if (cnt == CW'(NSETS)) st <= SPILL;
            else begin st <= WAIT; tmr <= 8'(CALL_LAT - 1); end
          end else if (ret_req) begin
            op_call <= 1'b0;
            if (depth == '0) err <= 1'b1;
            else if (cnt == CW'(1)) st <= FILL;
            else begin st <= WAIT; tmr <= 8'(RET_LAT - 1); end
          end
        end
        SPILL, FILL: if (mem_rdy) begin
          beat <= beat + 1'b1;
          if (last) begin
            st  <= WAIT;
            tmr <= op_call ? 8'(CALL_LAT - 1) : 8'(RET_LAT - 1);
          end
        end
        WAIT: begin
          if (tmr != 8'd0) tmr <= tmr - 1'b1;
          else begin
            st   <= IDLE;
            done <= 1'b1;
            if (op_call) begin
              cur <= cur + 1'b1; depth <= depth + 1'b1; fp <= fp + AW'(FRAME);
              if (cnt != CW'(NSETS)) cnt <= cnt + 1'b1;
            end else begin
              cur <= prev; depth <= depth - 1'b1; fp <= fp - AW'(FRAME);
              if (cnt != CW'(1)) cnt <= cnt - 1'b1;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CW'(1)) && (cnt <= CW'(NSETS)));

  // R8
  cnt_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    DEPTH_W'(cnt) <= depth + 1'b1);

  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(fp) && !done && !mem_req));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  fp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(done)) |-> $stable(fp));
endmodule

// File: tb/sim_regset_cache.sv
module sim_regset_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  logic call_req = 0, ret_req = 0, rf_we = 0, mem_rdy = 1;
  logic [3:0] rf_idx = 0;
  logic [31:0] rf_wdata = 0, mem_rdata;
  logic done, err, mem_req, mem_we;
  logic [31:0] fp, rf_rdata, mem_addr, mem_wdata;
  logic [31:0] mem [0:255];
  int total = 0, bad = 0, beats = 0;
  logic stall = 0;
  logic [7:0] lfsr = 8'h5b;

  always #2 clk = ~clk;

  regset_cache u0 (.clk, .rst_n, .call_req, .ret_req, .done, .err, .fp,
    .rf_we, .rf_idx, .rf_wdata, .rf_rdata, .mem_req, .mem_we, .mem_addr,
    .mem_wdata, .mem_rdata, .mem_rdy);

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_rdy) begin
      beats <= beats + 1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rdy <= stall ? lfsr[0] : 1'b1;
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] val(input int ph, input int d, input int i);
    return 32'hC0DE0000 + ph * 32'h10000 + d * 256 + i;
  endfunction

  task automatic fill_regs(input int ph, input int d);
    for (int i = 0; i < 16; i++) begin
      rf_we = 1; rf_idx = 4'(i); rf_wdata = val(ph, d, i);
      @(posedge clk); @(negedge clk);
    end
    rf_we = 0;
  endtask

  task automatic check_regs(input int ph, input int d);
    for (int i = 0; i < 16; i++) begin
      rf_idx = 4'(i); #1;
      check("R8 register contents", rf_rdata, val(ph, d, i));
    end
  endtask

  task automatic do_op(input logic is_call, output int n, output int nb);
    int b0;
    b0 = beats;
    call_req = is_call; ret_req = !is_call;
    @(posedge clk); @(negedge clk);
    call_req = 0; ret_req = 0;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk); @(negedge clk); n++;
    end
    nb = beats - b0;
    @(posedge clk); @(negedge clk);
    check("R10 done single pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, nb;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 fp", fp, 0);
    check("R1 done", {31'b0, done}, 0);
    check("R1 err", {31'b0, err}, 0);
    check("R1 mem_req", {31'b0, mem_req}, 0);

    // phase 1: memory always ready, exact latencies
    fill_regs(1, 0);
    for (int d = 1; d <= 9; d++) begin
      do_op(1'b1, n, nb);
      if (d >= 4) begin
        check("R4 spill call latency", n, 25);
        check("R4 spill beat count", nb, 16);
      end else begin
        check("R2 hit call latency", n, 9);
        check("R2 hit call no memory", nb, 0);
      end
      check("R7 fp after call", fp, d * 64);
      fill_regs(1, d);
    end
    // spilled frames must sit at their own slots, register 0 first (R4)
    for (int d = 0; d <= 5; d++)
      check("R4 spilled word", mem[d * 16 + 3], val(1, d, 3));
    for (int t = 8; t >= 0; t--) begin
      do_op(1'b0, n, nb);
      if (t >= 6) begin
        check("R3 hit return latency", n, 7);
        check("R3 hit return no memory", nb, 0);
      end else begin
        check("R5 fill return latency", n, 23);
        check("R5 fill beat count", nb, 16);
      end
      check("R7 fp after return", fp, t * 64);
      check_regs(1, t);
    end

    // R9: return with no open call
    n = beats;
    ret_req = 1; @(posedge clk); @(negedge clk); ret_req = 0;
    check("R9 err raised", {31'b0, err}, 1);
    check("R9 no done", {31'b0, done}, 0);
    @(posedge clk); @(negedge clk);
    check("R9 err one cycle", {31'b0, err}, 0);
    check("R9 fp unchanged", fp, 0);
    check("R9 no memory", beats - n, 0);
    check_regs(1, 0);
    do_op(1'b1, n, nb);
    check("R9 state intact, next call hits", n, 9);
    do_op(1'b0, n, nb);
    check("R3 return after err", n, 7);

    // R10: requests and writes ignored while busy
    call_req = 1; @(posedge clk); @(negedge clk); call_req = 0;
    rf_we = 1; rf_idx = 0; rf_wdata = 32'hBAD0BAD0; ret_req = 1;
    @(posedge clk); @(negedge clk);
    rf_we = 0; ret_req = 0;
    while (!done) begin @(posedge clk); @(negedge clk); end
    @(posedge clk); @(negedge clk);
    check("R10 busy request ignored", fp, 64);
    do_op(1'b0, n, nb);
    check("R10 busy write ignored", fp, 0);
    check_regs(1, 0);

    // phase 2: stalled memory, new data
    stall = 1;
    fill_regs(2, 0);
    for (int d = 1; d <= 7; d++) begin
      do_op(1'b1, n, nb);
      check("R6 stalled spill beats", nb, (d >= 4) ? 16 : 0);
      fill_regs(2, d);
    end
    for (int t = 6; t >= 0; t--) begin
      do_op(1'b0, n, nb);
      check("R6 stalled fill beats", nb, (t <= 3) ? 16 : 0);
      if (t <= 3) check("R6 stall stretches fill", {31'b0, n >= 23}, 1);
      check("R7 fp stalled", fp, t * 64);
      check_regs(2, t);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule